// File: doc/BRIEF.md
# Decode-Stage Hazard Controller

This block sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the two source register specifiers of the instruction in decode and at the destination specifiers of the instructions now in execute, memory and writeback. From this comparison it picks a forwarding source for each operand. It also raises a single stall that freezes fetch and decode and injects a bubble into the decode/execute register.

Besides read-after-write hazards, the stall covers three other cases. The first is a load in execute whose result a decode operand needs. The second is a conflict on the register-file write port when a load in execute is followed by an instruction that writes back early. The third involves the iterative multiplier. A decode instruction stalls if it would overwrite a register that an outstanding multiply has not yet written, and a multiply in decode stalls while the multiplier is busy. The block records the destination of the outstanding multiply itself. It captures that destination when a multiply leaves decode and drops it when the multiplier reports completion.

All control pins are plain levels with no handshake. The selects and the stall are combinational functions of the current stage contents and the recorded multiply state.

Top module: `hazard_ctrl`

## Requirements
- R1: An operand matches a later stage only when its read enable is high, that stage's write enable is high, the specifiers are equal and the specifier is not register 0. An operand with no match selects the register file.
- R2: An operand that names register 0 always selects the register file and never causes a stall, whatever the later stages write.
- R3: The select codes are 0 for the register file, 1 for execute, 2 for memory and 3 for writeback. When several stages match, execute wins over memory and memory wins over writeback.
- R4: If the execute-stage match for an operand is a load, stall goes high and that operand's select is 0.
- R5: Matches found only in memory or writeback never raise stall.
- R6: The fetch enable and the decode enable both equal the inverse of stall, and the bubble-insert output equals stall.
- R7: A load in execute together with an early-writeback instruction in decode raises stall, with or without any register match.
- R8: A multiply in decode raises stall while the multiplier-ready input is low.
- R9: A multiply that leaves decode (multiply flag high and stall low at a clock edge) records its destination as outstanding. The record clears on a completion pulse that has no new issue in the same cycle, and also on reset.
- R10: While a multiply is outstanding with a nonzero destination, a decode instruction that writes the same register raises stall.
- R11: The two operands are resolved independently and may select different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the outstanding-multiply record |
| rst_n | input | 1 | Active-low synchronous reset |
| d_rd_en0 | input | 1 | Decode operand 0 read enable |
| d_rd_reg0 | input | REG_AW | Decode operand 0 register specifier |
| d_rd_en1 | input | 1 | Decode operand 1 read enable |
| d_rd_reg1 | input | REG_AW | Decode operand 1 register specifier |
| d_wr_en | input | 1 | Decode instruction writes a register |
| d_wr_reg | input | REG_AW | Decode destination specifier |
| d_mul | input | 1 | Decode instruction is a multiply |
| d_early_wb | input | 1 | Decode instruction writes back early |
| x_wr_en | input | 1 | Execute instruction writes a register |
| x_wr_reg | input | REG_AW | Execute destination specifier |
| x_load | input | 1 | Execute instruction is a load |
| m_wr_en | input | 1 | Memory-stage write enable |
| m_wr_reg | input | REG_AW | Memory-stage destination specifier |
| w_wr_en | input | 1 | Writeback-stage write enable |
| w_wr_reg | input | REG_AW | Writeback-stage destination specifier |
| mul_ready | input | 1 | Multiplier can accept a new operation |
| mul_done | input | 1 | Outstanding multiply has written its result |
| fwd_sel0 | output | 2 | Operand 0 source select |
| fwd_sel1 | output | 2 | Operand 1 source select |
| stall | output | 1 | Global stall |
| f_en | output | 1 | Fetch register enable |
| d_en | output | 1 | Decode register enable |
| dx_bubble | output | 1 | Insert no-op into the decode/execute register |

## Verification
The bench uses the default 5-bit register specifier but draws every specifier from registers 0 to 3. This makes matches against one, two or all three later stages frequent, and register 0 turns up in about a quarter of the draws. The multiply flag, the ready and completion inputs and the load flag are randomised at rates that issue multiplies often. As a result, waits on an outstanding destination, overlapping issue and completion, and load-use against both operands all occur many times in the random run.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SRC_RF = 2'd0,
    SRC_X  = 2'd1,
    SRC_M  = 2'd2,
    SRC_W  = 2'd3
  } fwd_src_e;
endpackage

// File: rtl/hazard_src_sel.sv
module hazard_src_sel
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_reg,
  input  logic              x_wr_en,
  input  logic [REG_AW-1:0] x_wr_reg,
  input  logic              x_load,
  input  logic              m_wr_en,
  input  logic [REG_AW-1:0] m_wr_reg,
  input  logic              w_wr_en,
  input  logic [REG_AW-1:0] w_wr_reg,
  output fwd_src_e          sel,
  output logic              load_stall
);
  logic live, hit_x, hit_m, hit_w;

  assign live  = rd_en && (rd_reg != '0);
  assign hit_x = live && x_wr_en && (x_wr_reg == rd_reg);
  assign hit_m = live && m_wr_en && (m_wr_reg == rd_reg);
  assign hit_w = live && w_wr_en && (w_wr_reg == rd_reg);

  always_comb begin
    load_stall = 1'b0;
    sel        = SRC_RF;
    if (hit_x) begin
      if (x_load) load_stall = 1'b1;
      else        sel        = SRC_X;
    end else if (hit_m) begin
      sel = SRC_M;
    end else if (hit_w) begin
      sel = SRC_W;
    end
  end

  // R3: writeback is chosen only when memory holds no newer copy
  a_r3_youngest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_W) |-> !(m_wr_en && m_wr_reg == rd_reg));

  // R2: register 0 is never forwarded and never stalls
  a_r2_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reg == '0) |-> (sel == SRC_RF && !load_stall));

  // R1: a forwarded operand must have been read
  a_r1_read_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SRC_RF) |-> rd_en);
endmodule

// File: rtl/hazard_mul_track.sv
module hazard_mul_track #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [REG_AW-1:0] issue_reg,
  input  logic              done,
  input  logic              d_wr_en,
  input  logic [REG_AW-1:0] d_wr_reg,
  output logic              waw_stall
);
  logic              pend_q;
  logic [REG_AW-1:0] dest_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dest_q <= '0;
    end else if (issue) begin
      pend_q <= 1'b1;
      dest_q <= issue_reg;
    end else if (done) begin
      pend_q <= 1'b0;
    end
  end

  assign waw_stall = pend_q && d_wr_en && (d_wr_reg == dest_q) && (dest_q != '0);

  // R9: an issue is recorded on the following cycle
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (pend_q && dest_q == $past(issue_reg)));

  // R9: completion without a new issue drops the record
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !issue) |=> !pend_q);
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_rd_en0,
  input  logic [REG_AW-1:0] d_rd_reg0,
  input  logic              d_rd_en1,
  input  logic [REG_AW-1:0] d_rd_reg1,
  input  logic              d_wr_en,
  input  logic [REG_AW-1:0] d_wr_reg,
  input  logic              d_mul,
  input  logic              d_early_wb,
  input  logic              x_wr_en,
  input  logic [REG_AW-1:0] x_wr_reg,
  input  logic              x_load,
  input  logic              m_wr_en,
  input  logic [REG_AW-1:0] m_wr_reg,
  input  logic              w_wr_en,
  input  logic [REG_AW-1:0] w_wr_reg,
  input  logic              mul_ready,
  input  logic              mul_done,
  output logic [1:0]        fwd_sel0,
  output logic [1:0]        fwd_sel1,
  output logic              stall,
  output logic              f_en,
  output logic              d_en,
  output logic              dx_bubble
);
  localparam int NSRC = 2;

  logic [NSRC-1:0]   src_en;
  logic [REG_AW-1:0] src_reg [NSRC];
  fwd_src_e          src_sel [NSRC];
  logic [NSRC-1:0]   src_ld_stall;
  logic              port_stall, busy_stall, waw_stall, mul_issue;

  assign src_en     = {d_rd_en1, d_rd_en0};
  assign src_reg[0] = d_rd_reg0;
  assign src_reg[1] = d_rd_reg1;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hazard_src_sel #(.REG_AW(REG_AW)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (src_en[g]),
      .rd_reg     (src_reg[g]),
      .x_wr_en    (x_wr_en),
      .x_wr_reg   (x_wr_reg),
      .x_load     (x_load),
      .m_wr_en    (m_wr_en),
      .m_wr_reg   (m_wr_reg),
      .w_wr_en    (w_wr_en),
      .w_wr_reg   (w_wr_reg),
      .sel        (src_sel[g]),
      .load_stall (src_ld_stall[g])
    );
  end

  assign port_stall = x_load && d_early_wb;
  assign busy_stall = d_mul && !mul_ready;
  assign mul_issue  = d_mul && !stall;

  hazard_mul_track #(.REG_AW(REG_AW)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (mul_issue),
    .issue_reg (d_wr_reg),
    .done      (mul_done),
    .d_wr_en   (d_wr_en),
    .d_wr_reg  (d_wr_reg),
    .waw_stall (waw_stall)
  );

  assign stall     = (|src_ld_stall) || port_stall || busy_stall || waw_stall;
  assign f_en      = !stall;
  assign d_en      = !stall;
  assign dx_bubble = stall;
  assign fwd_sel0  = src_sel[0];
  assign fwd_sel1  = src_sel[1];

  // R7: load ahead of an early writer always holds decode
  a_r7_port_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (x_load && d_early_wb) |-> (stall && !d_en));

  // R8: a multiply cannot leave decode while the unit is busy
  a_r8_mul_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (d_mul && !mul_ready) |-> (!f_en && dx_bubble));

  // R4: a load-use operand is never reported as forwarded from execute
  a_r4_load_use: assert property (@(posedge clk) disable iff (!rst_n)
    (x_load && (fwd_sel0 == 2'd1 || fwd_sel1 == 2'd1)) |-> 1'b0);
endmodule

// File: tb/hazard_ctrl_bench.sv
`timescale 1ns/1ps
module hazard_ctrl_bench;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_rd_en0, d_rd_en1, d_wr_en, d_mul, d_early_wb;
  logic [AW-1:0] d_rd_reg0, d_rd_reg1, d_wr_reg, x_wr_reg, m_wr_reg, w_wr_reg;
  logic x_wr_en, x_load, m_wr_en, w_wr_en, mul_ready, mul_done;
  logic [1:0] fwd_sel0, fwd_sel1;
  logic stall, f_en, d_en, dx_bubble;

  int checks = 0;
  int errors = 0;
  logic model_pend = 1'b0;
  logic [AW-1:0] model_dest = '0;

  always #2.5 clk = ~clk;

  hazard_ctrl #(.REG_AW(AW)) u_hazard_ctrl (
    .clk(clk), .rst_n(rst_n),
    .d_rd_en0(d_rd_en0), .d_rd_reg0(d_rd_reg0), .d_rd_en1(d_rd_en1), .d_rd_reg1(d_rd_reg1),
    .d_wr_en(d_wr_en), .d_wr_reg(d_wr_reg), .d_mul(d_mul), .d_early_wb(d_early_wb),
    .x_wr_en(x_wr_en), .x_wr_reg(x_wr_reg), .x_load(x_load),
    .m_wr_en(m_wr_en), .m_wr_reg(m_wr_reg), .w_wr_en(w_wr_en), .w_wr_reg(w_wr_reg),
    .mul_ready(mul_ready), .mul_done(mul_done),
    .fwd_sel0(fwd_sel0), .fwd_sel1(fwd_sel1), .stall(stall),
    .f_en(f_en), .d_en(d_en), .dx_bubble(dx_bubble)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // returns {load_stall, select}
  function automatic logic [2:0] ref_op(logic en, logic [AW-1:0] r);
    logic live;
    live = en && (r != 0);
    if (live && x_wr_en && x_wr_reg == r) return x_load ? 3'b100 : 3'b001;
    if (live && m_wr_en && m_wr_reg == r) return 3'b010;
    if (live && w_wr_en && w_wr_reg == r) return 3'b011;
    return 3'b000;
  endfunction

  function automatic logic ref_stall();
    logic [2:0] a, b;
    a = ref_op(d_rd_en0, d_rd_reg0);
    b = ref_op(d_rd_en1, d_rd_reg1);
    return a[2] || b[2] || (x_load && d_early_wb) || (d_mul && !mul_ready) ||
           (model_pend && d_wr_en && d_wr_reg == model_dest && model_dest != 0);
  endfunction

  task automatic idle();
    d_rd_en0 = 0; d_rd_reg0 = 0; d_rd_en1 = 0; d_rd_reg1 = 0;
    d_wr_en = 0; d_wr_reg = 0; d_mul = 0; d_early_wb = 0;
    x_wr_en = 0; x_wr_reg = 0; x_load = 0;
    m_wr_en = 0; m_wr_reg = 0; w_wr_en = 0; w_wr_reg = 0;
    mul_ready = 1; mul_done = 0;
  endtask

  // compare all outputs with the model, then cross one clock edge
  task automatic cyc();
    logic [2:0] e0, e1;
    logic es;
    #1;
    e0 = ref_op(d_rd_en0, d_rd_reg0);
    e1 = ref_op(d_rd_en1, d_rd_reg1);
    es = ref_stall();
    chk("R3 R11 sel0", fwd_sel0, e0[1:0]);
    chk("R3 R11 sel1", fwd_sel1, e1[1:0]);
    chk("R4 R5 R10 stall", stall, es);
    chk("R6 f_en", f_en, !es);
    chk("R6 d_en", d_en, !es);
    chk("R6 bubble", dx_bubble, es);
    @(posedge clk);
    if (!rst_n) model_pend = 0;
    else if (d_mul && !es) begin model_pend = 1; model_dest = d_wr_reg; end
    else if (mul_done) model_pend = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    @(negedge clk);
    #1;
    chk("R9 reset stall", stall, 0);
    chk("R6 reset f_en", f_en, 1);
    cyc(); cyc();
    rst_n = 1;

    // R2: register 0 everywhere, including a load in execute
    d_rd_en0 = 1; d_rd_en1 = 1; x_wr_en = 1; x_load = 1; m_wr_en = 1; w_wr_en = 1;
    #1; chk("R2 sel0", fwd_sel0, 0); chk("R2 stall", stall, 0);
    cyc();

    // R3 priority and R1 enables
    idle(); d_rd_en0 = 1; d_rd_reg0 = 5;
    x_wr_en = 1; x_wr_reg = 5; m_wr_en = 1; m_wr_reg = 5; w_wr_en = 1; w_wr_reg = 5;
    #1; chk("R3 x wins", fwd_sel0, 1); cyc();
    x_wr_en = 0; #1; chk("R3 m wins", fwd_sel0, 2); cyc();
    m_wr_en = 0; #1; chk("R3 w only", fwd_sel0, 3); chk("R5 no stall", stall, 0); cyc();
    d_rd_en0 = 0; #1; chk("R1 read off", fwd_sel0, 0); cyc();

    // R4 load-use
    idle(); d_rd_en1 = 1; d_rd_reg1 = 6; x_wr_en = 1; x_wr_reg = 6; x_load = 1;
    m_wr_en = 1; m_wr_reg = 6;
    #1; chk("R4 stall", stall, 1); chk("R4 sel1", fwd_sel1, 0); chk("R6 bubble", dx_bubble, 1);
    cyc();

    // R7 write-port conflict without a match
    idle(); x_wr_en = 1; x_wr_reg = 9; x_load = 1; d_early_wb = 1;
    #1; chk("R7 stall", stall, 1); cyc();

    // R8 busy multiplier
    idle(); d_mul = 1; mul_ready = 0; d_wr_en = 1; d_wr_reg = 7;
    #1; chk("R8 stall", stall, 1); cyc();

    // R9 issue then R10 overwrite wait
    mul_ready = 1; #1; chk("R9 issue no stall", stall, 0); cyc();
    idle(); d_wr_en = 1; d_wr_reg = 7; mul_done = 1;
    #1; chk("R10 waw stall", stall, 1); cyc();
    mul_done = 0; #1; chk("R9 cleared", stall, 0); cyc();

    // R11 independent operands
    idle(); d_rd_en0 = 1; d_rd_reg0 = 2; d_rd_en1 = 1; d_rd_reg1 = 3;
    x_wr_en = 1; x_wr_reg = 2; w_wr_en = 1; w_wr_reg = 3;
    #1; chk("R11 sel0", fwd_sel0, 1); chk("R11 sel1", fwd_sel1, 3); cyc();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      d_rd_en0 = 1'($urandom % 2); d_rd_reg0 = AW'($urandom % 4);
      d_rd_en1 = 1'($urandom % 2); d_rd_reg1 = AW'($urandom % 4);
      d_wr_en = 1'($urandom % 2); d_wr_reg = AW'($urandom % 4);
      d_mul = ($urandom % 5) == 0; d_early_wb = ($urandom % 3) == 0;
      x_wr_en = 1'($urandom % 2); x_wr_reg = AW'($urandom % 4); x_load = ($urandom % 4) == 0;
      m_wr_en = 1'($urandom % 2); m_wr_reg = AW'($urandom % 4);
      w_wr_en = 1'($urandom % 2); w_wr_reg = AW'($urandom % 4);
      mul_ready = ($urandom % 4) != 0; mul_done = ($urandom % 4) == 0;
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule